// File: doc/BRIEF.md
# Half-Bridge Command Encoder with Shoot-Through Lockout

This block holds the synchronous control logic for one phase of a half bridge. Two logic commands come in: `hs_cmd_n` requests the high-side switch when it is low, and `ls_cmd` requests the low-side switch when it is high. The low-side gate enable is driven locally after a programmable matching delay. The high-side switch belongs to a remote driver that cannot see a level. It is told what to do by pulse trains on two separate lines. A turn-on request is a pair of pulses on `hs_on_pulse`. A turn-off request is a single pulse on `hs_off_pulse`. A set/reset lockout refuses any command that would put both switches in conduction. A supply-valid input (`supply_ok`) silences every output while it is low.

All three inputs pass through a synchronizer before edges are detected. The lockout stage turns edges into train requests and a low-side request level. The transmitter is a state machine with the states TX_IDLE, TX_ON_HI1, TX_ON_GAP, TX_ON_HI2, TX_OFF_HI and TX_REST, and it has these transitions:
- TX_IDLE goes to TX_ON_HI1 on an on request, or to TX_OFF_HI on an off request. A fresh request wins over a queued one.
- The states TX_ON_HI1, TX_ON_GAP and TX_ON_HI2 follow one another as each down-counter reaches zero.
- TX_ON_HI2 and TX_OFF_HI both go to TX_REST.
- TX_REST goes back to TX_IDLE.
- A supply loss sends any state to TX_IDLE.

A request that arrives while the transmitter is busy is held in a one-entry slot, and a newer request overwrites it. The low-side request passes through a shift-register delay line to reach `ls_gate`.

Top module: `hb_cmd_encoder`

## Requirements
- R1: While `rst_n` is low, `ls_gate`, `hs_on_pulse` and `hs_off_pulse` are all 0.
- R2: With the high side off and the supply valid, a change of `ls_cmd` shows up on `ls_gate` exactly SYNC_STAGES+LS_DELAY clock edges after the first edge that samples the new value. A 0-to-1 change of `ls_cmd` arms the low-side path.
- R3: A falling edge of `hs_cmd_n` that is accepted produces two pulses on `hs_on_pulse`. Each pulse lasts PULSE_CYC cycles, and GAP_CYC low cycles separate them. The first pulse is high SYNC_STAGES+1 edges after the sampling edge.
- R4: Every rising edge of `hs_cmd_n` while the supply is valid produces exactly one PULSE_CYC-cycle pulse on `hs_off_pulse`, with the same latency as R3.
- R5: `hs_on_pulse` and `hs_off_pulse` are never high together. Every train is followed by REST_CYC quiet cycles and one idle cycle before the next train starts.
- R6: A falling edge of `hs_cmd_n` is ignored while the synchronized `ls_cmd` is 1. No on pulses are sent, and the high side stays off until a later falling edge is accepted.
- R7: While the high side is on, `ls_gate` stays 0 whatever `ls_cmd` does. After a rising edge of `hs_cmd_n`, a held `ls_cmd` reaches `ls_gate` SYNC_STAGES+LS_DELAY+1 edges after the sampling edge.
- R8: An edge that arrives during a train is queued and sent in full after that train and its rest period. When several edges arrive during one train, only the newest is kept.
- R9: When `supply_ok` goes low, all three outputs are 0 from SYNC_STAGES+1 edges later. The train in progress and the queue are cleared, and all command edges are ignored while the supply is low.
- R10: When `supply_ok` goes high again (this includes the first time after reset), one off pulse is sent SYNC_STAGES+1 edges after the sampling edge. `ls_gate` then stays 0 until `ls_cmd` makes a fresh 0-to-1 change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hs_cmd_n | input | 1 | High-side command, 0 requests conduction |
| ls_cmd | input | 1 | Low-side command, 1 requests conduction |
| supply_ok | input | 1 | Supply valid, 0 locks out all outputs |
| ls_gate | output | 1 | Delayed low-side gate enable |
| hs_on_pulse | output | 1 | Turn-on signalling line (double pulse) |
| hs_off_pulse | output | 1 | Turn-off signalling line (single pulse) |

## Verification
The hardest situation to reach is a queued request that meets a supply loss or a second overwrite in the middle of a train. The slot only fills during a window tens of cycles wide, after the synchronizer delay. The stimulus therefore times new `hs_cmd_n` edges by counting cycles from the command that started the train. It flips the command back and forth inside the first pulse, and separately drops `supply_ok` while a pulse is high. It then follows both lines cycle by cycle against a waveform computed from the timing parameters.

// File: rtl/hbe_pkg.sv
package hbe_pkg;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_ON_HI1,
        TX_ON_GAP,
        TX_ON_HI2,
        TX_OFF_HI,
        TX_REST
    } tx_state_e;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/hbe_sync.sv
module hbe_sync #(
    parameter int               WIDTH   = 1,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            for (int s = STAGES - 1; s > 0; s--) begin
                chain_q[s] <= chain_q[s-1];
            end
            chain_q[0] <= din;
        end
    end

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/hbe_lockout.sv
module hbe_lockout (
    input  logic clk,
    input  logic rst_n,
    input  logic hs_n_s,
    input  logic ls_s,
    input  logic sup_s,
    output logic req_on,
    output logic req_off,
    output logic ls_req,
    output logic abort
);

    logic hs_prev_q, ls_prev_q, sup_prev_q;
    logic hs_on_q, armed_q;
    logic live, hs_fall, hs_rise, ls_rise, sup_back;

    always_comb begin
        live     = sup_s & sup_prev_q;
        hs_fall  = hs_prev_q & ~hs_n_s;
        hs_rise  = ~hs_prev_q & hs_n_s;
        ls_rise  = ls_s & ~ls_prev_q;
        sup_back = sup_s & ~sup_prev_q;
        req_on   = live & hs_fall & ~ls_s;
        req_off  = (live & hs_rise) | sup_back;
        abort    = ~sup_s;
        ls_req   = live & ls_s & ~hs_on_q & (armed_q | ls_rise);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_prev_q  <= 1'b1;
            ls_prev_q  <= 1'b0;
            sup_prev_q <= 1'b0;
            hs_on_q    <= 1'b0;
            armed_q    <= 1'b0;
        end else begin
            hs_prev_q  <= hs_n_s;
            ls_prev_q  <= ls_s;
            sup_prev_q <= sup_s;
            if (!sup_s) begin
                hs_on_q <= 1'b0;
                armed_q <= 1'b0;
            end else begin
                if (req_on) begin
                    hs_on_q <= 1'b1;
                end else if (live && hs_rise) begin
                    hs_on_q <= 1'b0;
                end
                if (live && ls_rise) begin
                    armed_q <= 1'b1;
                end
            end
        end
    end

    // R6: the high side only becomes on when low side was not requested
    assert_refuse_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_on_q) |-> $past(!ls_s));

    // R9: supply loss clears the lockout and the low-side arming
    assert_unpowered_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !sup_s |=> (!hs_on_q && !armed_q));

endmodule

// File: rtl/hbe_pulse_tx.sv
module hbe_pulse_tx
    import hbe_pkg::*;
#(
    parameter int PULSE_CYC = 16,
    parameter int GAP_CYC   = 16,
    parameter int REST_CYC  = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_on,
    input  logic req_off,
    input  logic abort,
    output logic on_line,
    output logic off_line
);

    localparam int MAX_CYC = max3(PULSE_CYC, GAP_CYC, REST_CYC);
    localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

    tx_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             slot_v_q, slot_v_d;
    logic             slot_on_q, slot_on_d;
    logic             any_req, go, go_on, done;

    always_comb begin
        any_req   = req_on | req_off;
        done      = (cnt_q == '0);
        state_d   = state_q;
        cnt_d     = done ? cnt_q : cnt_q - 1'b1;
        slot_v_d  = slot_v_q;
        slot_on_d = slot_on_q;
        go        = 1'b0;
        go_on     = 1'b0;

        if (any_req && state_q != TX_IDLE) begin
            slot_v_d  = 1'b1;
            slot_on_d = req_on;
        end

        unique case (state_q)
            TX_IDLE: begin
                slot_v_d = 1'b0;
                if (any_req) begin
                    go    = 1'b1;
                    go_on = req_on;
                end else if (slot_v_q) begin
                    go    = 1'b1;
                    go_on = slot_on_q;
                end
                if (go) begin
                    state_d = go_on ? TX_ON_HI1 : TX_OFF_HI;
                    cnt_d   = CNT_W'(PULSE_CYC - 1);
                end
            end
            TX_ON_HI1: begin
                if (done) begin
                    state_d = TX_ON_GAP;
                    cnt_d   = CNT_W'(GAP_CYC - 1);
                end
            end
            TX_ON_GAP: begin
                if (done) begin
                    state_d = TX_ON_HI2;
                    cnt_d   = CNT_W'(PULSE_CYC - 1);
                end
            end
            TX_ON_HI2, TX_OFF_HI: begin
                if (done) begin
                    state_d = TX_REST;
                    cnt_d   = CNT_W'(REST_CYC - 1);
                end
            end
            TX_REST: begin
                if (done) begin
                    state_d = TX_IDLE;
                end
            end
            default: state_d = TX_IDLE;
        endcase

        if (abort) begin
            state_d  = TX_IDLE;
            cnt_d    = '0;
            slot_v_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= TX_IDLE;
            cnt_q     <= '0;
            slot_v_q  <= 1'b0;
            slot_on_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            cnt_q     <= cnt_d;
            slot_v_q  <= slot_v_d;
            slot_on_q <= slot_on_d;
        end
    end

    always_comb begin
        on_line  = (state_q == TX_ON_HI1) || (state_q == TX_ON_HI2);
        off_line = (state_q == TX_OFF_HI);
    end

    // R5: the two signalling lines never carry a pulse at once
    assert_lines_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(on_line && off_line));

    // R4: an off pulse only starts from the idle state
    assert_off_from_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(off_line) |-> $past(state_q) == TX_IDLE);

    // R5: an off pulse that ends normally is followed by the rest period
    assert_rest_after_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(off_line) && !$past(abort)) |-> state_q == TX_REST);

endmodule

// File: rtl/hbe_delay_line.sv
module hbe_delay_line #(
    parameter int DEPTH = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic din,
    output logic dout
);

    logic [DEPTH-1:0] stage_q;

    generate
        if (DEPTH == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q <= '0;
                else        stage_q <= flush ? 1'b0 : din;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)     stage_q <= '0;
                else if (flush) stage_q <= '0;
                else            stage_q <= {stage_q[DEPTH-2:0], din};
            end
        end
    endgenerate

    assign dout = stage_q[DEPTH-1];

    // R9: a flush empties the line by the next cycle
    assert_flush_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !dout);

endmodule

// File: rtl/hb_cmd_encoder.sv
module hb_cmd_encoder #(
    parameter int SYNC_STAGES = 2,
    parameter int PULSE_CYC   = 16,
    parameter int GAP_CYC     = 16,
    parameter int REST_CYC    = 16,
    parameter int LS_DELAY    = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hs_cmd_n,
    input  logic ls_cmd,
    input  logic supply_ok,
    output logic ls_gate,
    output logic hs_on_pulse,
    output logic hs_off_pulse
);

    logic [2:0] raw_in, sync_out;
    logic       hs_n_s, ls_s, sup_s;
    logic       req_on, req_off, ls_req, abort;

    assign raw_in = {supply_ok, ls_cmd, hs_cmd_n};

    hbe_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b001)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw_in),
        .dout (sync_out)
    );

    assign hs_n_s = sync_out[0];
    assign ls_s   = sync_out[1];
    assign sup_s  = sync_out[2];

    hbe_lockout u_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .hs_n_s (hs_n_s),
        .ls_s   (ls_s),
        .sup_s  (sup_s),
        .req_on (req_on),
        .req_off(req_off),
        .ls_req (ls_req),
        .abort  (abort)
    );

    hbe_pulse_tx #(
        .PULSE_CYC(PULSE_CYC),
        .GAP_CYC  (GAP_CYC),
        .REST_CYC (REST_CYC)
    ) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_on  (req_on),
        .req_off (req_off),
        .abort   (abort),
        .on_line (hs_on_pulse),
        .off_line(hs_off_pulse)
    );

    hbe_delay_line #(
        .DEPTH(LS_DELAY)
    ) u_dly (
        .clk  (clk),
        .rst_n(rst_n),
        .flush(abort),
        .din  (ls_req),
        .dout (ls_gate)
    );

    // R9: once the synchronized supply is low every output is silent next cycle
    assert_unpowered_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !sup_s |=> (!ls_gate && !hs_on_pulse && !hs_off_pulse));

endmodule

// File: tb/hb_cmd_encoder_tb_top.sv
`timescale 1ns/1ps
module hb_cmd_encoder_tb_top;

    localparam int SYNC = 2;
    localparam int W    = 16;
    localparam int G    = 16;
    localparam int R    = 16;
    localparam int D    = 20;
    localparam int L    = SYNC + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hs_cmd_n = 1'b1;
    logic ls_cmd = 1'b0;
    logic supply_ok = 1'b1;
    logic ls_gate, hs_on_pulse, hs_off_pulse;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 1'b0;

    int on_cnt = 0, off_cnt = 0, bad_w = 0, overlap = 0;
    int on_len = 0, off_len = 0;
    logic on_prev = 1'b0, off_prev = 1'b0;

    always #5 clk = ~clk;

    hb_cmd_encoder #(
        .SYNC_STAGES(SYNC), .PULSE_CYC(W), .GAP_CYC(G), .REST_CYC(R), .LS_DELAY(D)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .hs_cmd_n(hs_cmd_n), .ls_cmd(ls_cmd),
        .supply_ok(supply_ok), .ls_gate(ls_gate),
        .hs_on_pulse(hs_on_pulse), .hs_off_pulse(hs_off_pulse)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (hs_on_pulse && !on_prev) on_cnt <= on_cnt + 1;
        if (hs_off_pulse && !off_prev) off_cnt <= off_cnt + 1;
        if (hs_on_pulse && hs_off_pulse) overlap <= overlap + 1;
        if (hs_on_pulse) on_len <= on_len + 1;
        else begin
            if (on_len != 0 && on_len != W) bad_w <= bad_w + 1;
            on_len <= 0;
        end
        if (hs_off_pulse) off_len <= off_len + 1;
        else begin
            if (off_len != 0 && off_len != W) bad_w <= bad_w + 1;
            off_len <= 0;
        end
        on_prev  <= hs_on_pulse;
        off_prev <= hs_off_pulse;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        wait_cyc(3);
        chk({ls_gate, hs_on_pulse, hs_off_pulse} == 3'b000, "R1 outputs in reset",
            int'({ls_gate, hs_on_pulse, hs_off_pulse}), 0);
        rst_n = 1'b1;
        wait_cyc(60);
        chk(off_cnt == 1 && on_cnt == 0, "R10 off pulse after power-up", off_cnt, 1);
    endtask

    task automatic t_ls_follow();
        ls_cmd = 1'b1;
        wait_cyc(D + 1);
        chk(ls_gate == 1'b0, "R2 gate before delay", int'(ls_gate), 0);
        tick();
        chk(ls_gate == 1'b1, "R2 gate after delay", int'(ls_gate), 1);
        ls_cmd = 1'b0;
        wait_cyc(D + 1);
        chk(ls_gate == 1'b1, "R2 gate held before delay", int'(ls_gate), 1);
        tick();
        chk(ls_gate == 1'b0, "R2 gate released after delay", int'(ls_gate), 0);
        wait_cyc(5);
    endtask

    task automatic t_on_train();
        int bad = 0;
        int on0 = on_cnt;
        int b0 = bad_w;
        bit e;
        hs_cmd_n = 1'b0;
        for (int i = 1; i <= L + 2*W + G + R + 2; i++) begin
            tick();
            e = (i >= L && i < L + W) || (i >= L + W + G && i < L + 2*W + G);
            if (hs_on_pulse !== e || hs_off_pulse !== 1'b0) bad++;
        end
        chk(bad == 0, "R3 on-train waveform mismatches", bad, 0);
        chk(on_cnt - on0 == 2, "R3 on pulse count", on_cnt - on0, 2);
        chk(bad_w == b0, "R3 pulse widths", bad_w - b0, 0);
    endtask

    task automatic t_off_pulse();
        int bad = 0;
        int off0 = off_cnt;
        bit e;
        hs_cmd_n = 1'b1;
        for (int i = 1; i <= L + W + R + 2; i++) begin
            tick();
            e = (i >= L && i < L + W);
            if (hs_off_pulse !== e || hs_on_pulse !== 1'b0) bad++;
        end
        chk(bad == 0, "R4 off pulse waveform mismatches", bad, 0);
        chk(off_cnt - off0 == 1, "R4 off pulse count", off_cnt - off0, 1);
        chk(overlap == 0, "R5 lines overlapped", overlap, 0);
    endtask

    task automatic t_queue();
        int bad = 0;
        int b0 = bad_w;
        int off_start = L + 2*W + G + R + 1;
        bit eon, eoff;
        hs_cmd_n = 1'b0;
        for (int i = 1; i <= off_start + W + 3; i++) begin
            tick();
            if (i == 5) hs_cmd_n = 1'b1;
            eon  = (i >= L && i < L + W) || (i >= L + W + G && i < L + 2*W + G);
            eoff = (i >= off_start && i < off_start + W);
            if (hs_on_pulse !== eon || hs_off_pulse !== eoff) bad++;
        end
        chk(bad == 0, "R8 queued off train after rest (R5 spacing)", bad, 0);
        chk(bad_w == b0, "R8 queued pulses not truncated", bad_w - b0, 0);
        wait_cyc(R + 4);
    endtask

    task automatic t_latest();
        int on0 = on_cnt;
        int off0 = off_cnt;
        hs_cmd_n = 1'b0;
        wait_cyc(5);
        hs_cmd_n = 1'b1;
        wait_cyc(5);
        hs_cmd_n = 1'b0;
        wait_cyc(250);
        chk(on_cnt - on0 == 4, "R8 newest queued edge kept (on pulses)", on_cnt - on0, 4);
        chk(off_cnt - off0 == 0, "R8 overwritten off request dropped", off_cnt - off0, 0);
        hs_cmd_n = 1'b1;
        wait_cyc(L + W + R + 4);
        chk(off_cnt - off0 == 1, "R4 off pulse after queue test", off_cnt - off0, 1);
    endtask

    task automatic t_lockout_hs();
        int on0;
        int off0;
        ls_cmd = 1'b1;
        wait_cyc(D + 4);
        on0 = on_cnt;
        off0 = off_cnt;
        hs_cmd_n = 1'b0;
        wait_cyc(100);
        chk(on_cnt == on0, "R6 refused turn-on sent pulses", on_cnt - on0, 0);
        chk(ls_gate == 1'b1, "R6 low side kept on", int'(ls_gate), 1);
        ls_cmd = 1'b0;
        wait_cyc(D + 10);
        chk(on_cnt == on0, "R6 refused turn-on stays refused", on_cnt - on0, 0);
        hs_cmd_n = 1'b1;
        wait_cyc(L + W + R + 4);
        chk(off_cnt - off0 == 1, "R4 off pulse after refused on", off_cnt - off0, 1);
    endtask

    task automatic t_lockout_ls();
        int bad = 0;
        hs_cmd_n = 1'b0;
        wait_cyc(L + 2*W + G + R + 4);
        ls_cmd = 1'b1;
        for (int i = 0; i < D + 20; i++) begin
            tick();
            if (ls_gate !== 1'b0) bad++;
        end
        chk(bad == 0, "R7 low side held off while high side on", bad, 0);
        hs_cmd_n = 1'b1;
        wait_cyc(D + 2);
        chk(ls_gate == 1'b0, "R7 gate before matched delay", int'(ls_gate), 0);
        tick();
        chk(ls_gate == 1'b1, "R7 gate after high side off", int'(ls_gate), 1);
        ls_cmd = 1'b0;
        wait_cyc(D + 10);
    endtask

    task automatic t_supply_drop();
        int bad = 0;
        int on0;
        int off0;
        ls_cmd = 1'b1;
        wait_cyc(D + 5);
        chk(ls_gate == 1'b1, "R2 gate on before supply loss", int'(ls_gate), 1);
        supply_ok = 1'b0;
        wait_cyc(2);
        chk(ls_gate == 1'b1, "R9 gate before lockout latency", int'(ls_gate), 1);
        tick();
        chk(ls_gate == 1'b0, "R9 gate forced off", int'(ls_gate), 0);
        ls_cmd = 1'b0;
        supply_ok = 1'b1;
        wait_cyc(L + W + R + 10);
        hs_cmd_n = 1'b0;
        wait_cyc(L + 3);
        supply_ok = 1'b0;
        wait_cyc(2);
        chk(hs_on_pulse == 1'b1, "R9 pulse still high before latency", int'(hs_on_pulse), 1);
        tick();
        chk(hs_on_pulse == 1'b0, "R9 pulse aborted", int'(hs_on_pulse), 0);
        on0 = on_cnt;
        off0 = off_cnt;
        for (int i = 0; i < 120; i++) begin
            tick();
            if (i == 10) hs_cmd_n = 1'b1;
            if (i == 30) ls_cmd = 1'b1;
            if (i == 50) hs_cmd_n = 1'b0;
            if (ls_gate || hs_on_pulse || hs_off_pulse) bad++;
        end
        chk(bad == 0, "R9 outputs silent while unpowered", bad, 0);
        chk(on_cnt == on0 && off_cnt == off0, "R9 no trains while unpowered",
            on_cnt - on0 + off_cnt - off0, 0);
    endtask

    task automatic t_supply_return();
        int bad = 0;
        int on0 = on_cnt;
        bit e;
        supply_ok = 1'b1;
        for (int i = 1; i <= D + 60; i++) begin
            tick();
            e = (i >= L && i < L + W);
            if (hs_off_pulse !== e || hs_on_pulse !== 1'b0 || ls_gate !== 1'b0) bad++;
        end
        chk(bad == 0, "R10 single off pulse and low side disarmed", bad, 0);
        chk(on_cnt == on0, "R10 no on pulses on return", on_cnt - on0, 0);
        ls_cmd = 1'b0;
        wait_cyc(5);
        ls_cmd = 1'b1;
        wait_cyc(D + 1);
        chk(ls_gate == 1'b0, "R10 rearm before delay", int'(ls_gate), 0);
        tick();
        chk(ls_gate == 1'b1, "R10 fresh low-side edge rearms", int'(ls_gate), 1);
        ls_cmd = 1'b0;
        hs_cmd_n = 1'b1;
        wait_cyc(D + 40);
        chk(overlap == 0, "R5 no overlap over whole run", overlap, 0);
    endtask

    initial begin
        t_reset();
        t_ls_follow();
        t_on_train();
        t_off_pulse();
        t_queue();
        t_latest();
        t_lockout_hs();
        t_lockout_ls();
        t_supply_drop();
        t_supply_return();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        wait (cyc >= 50000 || done);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule